// File: doc/BRIEF.md
# Chained Descriptor Transfer Engine

The engine follows a linked list of four-word descriptors held in memory and turns each one into a single command for a serial shift engine. For every descriptor it fetches the control word, the buffer address and the link address. It issues one command that carries the byte count, the direction, the lane width, the bit order, the device select and the chip-select release flag. It then moves the payload between the buffer and the shifter byte streams, one memory word at a time. When the payload is done it writes a completion status into the descriptor, hands the descriptor back by clearing its ownership bit, and raises the events the descriptor asked for.

Software writes a chain of descriptors and sets the base address, holds the DMA enable high and pulses start. The walk ends on an end-of-list flag or on a null link. With poll enable set, a descriptor that software does not own yet is fetched again until it becomes owned. Without poll enable it is a fault. Dropping the DMA enable stops the engine wherever it is.

Top module: `dbp_walker`

## Requirements
- R1: When start_i is pulsed while dma_en_i is high, the engine reads the control word at base_addr_i, then the buffer address at offset 8 and the link at offset 12. A memory request stays asserted with a stable address until it is acknowledged.
- R2: Each owned descriptor produces exactly one command, held stable until it is accepted, before any of its data moves. The command fields are: length = control bits 8:0, receive = bit 20, lanes = 2 if bit 23 is set, else 1 if bit 22 is set, else 0, LSB-first = bit 25, device = bits 29:28, chip-select release = bit 30.
- R3: In a transmit descriptor, exactly `length` bytes are sent on the transmit stream. They are taken from consecutive buffer words, byte 0 first as bits 7:0.
- R4: In a receive descriptor, `length` received bytes are packed into consecutive buffer words, the first byte in bits 7:0. A partial last word is written with zeros above the received bytes.
- R5: After the payload, the status word (offset 4) is written with 0x8000_0000 plus the byte length. The control word is then written back with bit 31 cleared.
- R6: bd_done_o pulses for one cycle after the control write-back when control bit 16 is set. No completion event pulses in the same cycle as err_o.
- R7: pkt_done_o pulses at that same point only when control bits 17 and 18 are both set.
- R8: After a descriptor, the engine stops if control bit 19 is set or the link is 0. Otherwise it continues at the link address.
- R9: A control word with bit 31 clear pulses err_o and halts the engine when poll_en_i is low. With poll_en_i high, the same word is read again until it is owned, and no command is issued while it waits.
- R10: A length above 256 pulses err_o and halts the engine without issuing a command.
- R11: A memory access acknowledged with mem_err_i pulses err_o and halts the engine. No further memory request follows.
- R12: Lowering dma_en_i returns the engine to idle on the next cycle. There are then no memory requests, no command and no transmit data, and the descriptor is not written back.
- R13: A zero-length descriptor issues its command, moves no data and is completed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_en_i | input | 1 | Engine enable; low aborts |
| poll_en_i | input | 1 | Re-read descriptors that are not owned |
| start_i | input | 1 | Start pulse, taken in idle |
| base_addr_i | input | AW | Address of the first descriptor |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ack |
| mem_ack_i | input | 1 | Access complete |
| mem_err_i | input | 1 | Access faulted, valid with ack |
| cmd_valid_o | output | 1 | Command valid |
| cmd_ready_i | input | 1 | Command accepted |
| cmd_len_o | output | 9 | Byte count |
| cmd_rx_o | output | 1 | Receive direction |
| cmd_lanes_o | output | 2 | 0 single, 1 dual, 2 quad |
| cmd_lsb_o | output | 1 | LSB-first bit order |
| cmd_dev_o | output | 2 | Device select |
| cmd_cs_rel_o | output | 1 | Release chip select after this command |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_ready_i | input | 1 | Transmit byte taken |
| tx_data_o | output | 8 | Transmit byte |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_ready_o | output | 1 | Receive byte taken |
| rx_data_i | input | 8 | Receive byte |
| bd_done_o | output | 1 | Descriptor-done pulse |
| pkt_done_o | output | 1 | Packet-complete pulse |
| err_o | output | 1 | Error pulse |

## Verification
The bench targets these corner cases:
- A chain whose second descriptor is flagged end-of-list but still carries a non-null link to an owned descriptor. A walker that ignored the flag would consume that third descriptor.
- A 6-byte transmit and a 5-byte receive, which both end on a partial word. A bad byte counter would send extra bytes or leave stale data in the upper lanes of the last word.
- The ownership cases, both with and without polling. A wrong engine would either run on a descriptor it does not own, or fault where it should wait.
- An oversize length, a faulted buffer read and an enable drop part-way through a payload. The bench checks that no command, data or write-back slips out afterwards.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
  localparam int unsigned LEN_W    = 9;
  localparam int unsigned C_BDIRQ  = 16;
  localparam int unsigned C_PKTIRQ = 17;
  localparam int unsigned C_LIFM   = 18;
  localparam int unsigned C_EOL    = 19;
  localparam int unsigned C_RX     = 20;
  localparam int unsigned C_DUAL   = 22;
  localparam int unsigned C_QUAD   = 23;
  localparam int unsigned C_LSB    = 25;
  localparam int unsigned C_DEV    = 28;
  localparam int unsigned C_REL    = 30;
  localparam int unsigned C_OWN    = 31;
  localparam logic [31:0] ST_DONE  = 32'h8000_0000;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CTRL, S_RD_ADDR, S_RD_NEXT, S_CMD,
    S_TX_RD, S_TX_OUT, S_RX_IN, S_RX_WR, S_WB_STAT, S_WB_CTRL
  } state_e;
endpackage

// File: rtl/dbp_tx_unpack.sv
module dbp_tx_unpack (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  logic        load_i,
  input  logic [31:0] word_i,
  input  logic [2:0]  cnt_i,
  input  logic        ready_i,
  output logic        valid_o,
  output logic [7:0]  data_o,
  output logic        busy_o
);
  logic [31:0] sh_q;
  logic [2:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= word_i;
      cnt_q <= cnt_i;
    end else if (valid_o && ready_i) begin
      sh_q  <= {8'h00, sh_q[31:8]};
      cnt_q <= cnt_q - 3'd1;
    end
  end

  assign valid_o = (cnt_q != 3'd0);
  assign busy_o  = valid_o;
  assign data_o  = sh_q[7:0];

  p_tx_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !clear_i) |=> (valid_o && $stable(data_o)));
  p_tx_cnt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= 3'd4);
endmodule

// File: rtl/dbp_rx_pack.sv
module dbp_rx_pack (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  logic        en_i,
  input  logic [2:0]  target_i,
  input  logic        valid_i,
  input  logic [7:0]  data_i,
  output logic        ready_o,
  output logic        full_o,
  output logic [31:0] word_o
);
  logic [31:0] word_q;
  logic [2:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (valid_i && ready_o) begin
      word_q[cnt_q[1:0]*8 +: 8] <= data_i;
      cnt_q <= cnt_q + 3'd1;
    end
  end

  assign ready_o = en_i && (cnt_q < target_i);
  assign full_o  = en_i && (target_i != 3'd0) && (cnt_q == target_i);
  assign word_o  = word_q;

  p_pack_cnt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= 3'd4);
  p_pack_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !ready_o);
endmodule

// File: rtl/dbp_walker.sv
module dbp_walker
  import dbp_pkg::*;
#(
  parameter int AW      = 32,
  parameter int LEN_MAX = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dma_en_i,
  input  logic             poll_en_i,
  input  logic             start_i,
  input  logic [AW-1:0]    base_addr_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic [31:0]      mem_rdata_i,
  input  logic             mem_ack_i,
  input  logic             mem_err_i,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  output logic [LEN_W-1:0] cmd_len_o,
  output logic             cmd_rx_o,
  output logic [1:0]       cmd_lanes_o,
  output logic             cmd_lsb_o,
  output logic [1:0]       cmd_dev_o,
  output logic             cmd_cs_rel_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [7:0]       tx_data_o,
  input  logic             rx_valid_i,
  output logic             rx_ready_o,
  input  logic [7:0]       rx_data_i,
  output logic             bd_done_o,
  output logic             pkt_done_o,
  output logic             err_o
);
  localparam logic [LEN_W-1:0] LEN_LIM = LEN_W'(LEN_MAX);
  localparam logic [AW-1:0]    OFS_ST  = AW'(4);
  localparam logic [AW-1:0]    OFS_BUF = AW'(8);
  localparam logic [AW-1:0]    OFS_NXT = AW'(12);
  localparam logic [AW-1:0]    WSTEP   = AW'(4);

  state_e           state_q;
  logic [AW-1:0]    bd_q, buf_q, next_q;
  logic [31:0]      ctrl_q;
  logic [LEN_W-1:0] rem_q, rem_nx;
  logic [2:0]       chunk;
  logic             abort, acc_ok, acc_bad;
  logic             tx_busy, rx_full, pk_clear;
  logic [31:0]      pk_word;

  assign abort   = (state_q != S_IDLE) && !dma_en_i;
  assign acc_ok  = mem_req_o && mem_ack_i && !mem_err_i && dma_en_i;
  assign acc_bad = mem_req_o && mem_ack_i && mem_err_i && dma_en_i;
  assign chunk   = (rem_q >= LEN_W'(4)) ? 3'd4 : rem_q[2:0];
  assign rem_nx  = rem_q - LEN_W'(chunk);

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = bd_q;
    mem_wdata_o = '0;
    unique case (state_q)
      S_RD_CTRL: mem_req_o = 1'b1;
      S_RD_ADDR: begin mem_req_o = 1'b1; mem_addr_o = bd_q + OFS_BUF; end
      S_RD_NEXT: begin mem_req_o = 1'b1; mem_addr_o = bd_q + OFS_NXT; end
      S_TX_RD:   begin mem_req_o = 1'b1; mem_addr_o = buf_q; end
      S_RX_WR: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = buf_q; mem_wdata_o = pk_word;
      end
      S_WB_STAT: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = bd_q + OFS_ST;
        mem_wdata_o = ST_DONE | {23'd0, ctrl_q[LEN_W-1:0]};
      end
      S_WB_CTRL: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_wdata_o = {1'b0, ctrl_q[30:0]};
      end
      default: ;
    endcase
  end

  assign cmd_valid_o  = (state_q == S_CMD);
  assign cmd_len_o    = ctrl_q[LEN_W-1:0];
  assign cmd_rx_o     = ctrl_q[C_RX];
  assign cmd_lanes_o  = ctrl_q[C_QUAD] ? 2'd2 : (ctrl_q[C_DUAL] ? 2'd1 : 2'd0);
  assign cmd_lsb_o    = ctrl_q[C_LSB];
  assign cmd_dev_o    = ctrl_q[C_DEV +: 2];
  assign cmd_cs_rel_o = ctrl_q[C_REL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      bd_q       <= '0;
      buf_q      <= '0;
      next_q     <= '0;
      ctrl_q     <= '0;
      rem_q      <= '0;
      bd_done_o  <= 1'b0;
      pkt_done_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      bd_done_o  <= 1'b0;
      pkt_done_o <= 1'b0;
      err_o      <= 1'b0;
      if (abort) begin
        state_q <= S_IDLE;
      end else if (acc_bad) begin
        err_o   <= 1'b1;
        state_q <= S_IDLE;
      end else begin
        unique case (state_q)
          S_IDLE: if (start_i && dma_en_i) begin
            bd_q    <= base_addr_i;
            state_q <= S_RD_CTRL;
          end
          S_RD_CTRL: if (acc_ok) begin
            if (!mem_rdata_i[C_OWN]) begin
              // unowned: wait in place when polling, else fault
              if (!poll_en_i) begin
                err_o   <= 1'b1;
                state_q <= S_IDLE;
              end
            end else if (mem_rdata_i[LEN_W-1:0] > LEN_LIM) begin
              err_o   <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              ctrl_q  <= mem_rdata_i;
              state_q <= S_RD_ADDR;
            end
          end
          S_RD_ADDR: if (acc_ok) begin
            buf_q   <= mem_rdata_i[AW-1:0];
            state_q <= S_RD_NEXT;
          end
          S_RD_NEXT: if (acc_ok) begin
            next_q  <= mem_rdata_i[AW-1:0];
            rem_q   <= ctrl_q[LEN_W-1:0];
            state_q <= S_CMD;
          end
          S_CMD: if (cmd_ready_i) begin
            if (rem_q == '0)       state_q <= S_WB_STAT;
            else if (ctrl_q[C_RX]) state_q <= S_RX_IN;
            else                   state_q <= S_TX_RD;
          end
          S_TX_RD: if (acc_ok) begin
            rem_q   <= rem_nx;
            buf_q   <= buf_q + WSTEP;
            state_q <= S_TX_OUT;
          end
          S_TX_OUT: if (!tx_busy) state_q <= (rem_q == '0) ? S_WB_STAT : S_TX_RD;
          S_RX_IN:  if (rx_full) state_q <= S_RX_WR;
          S_RX_WR: if (acc_ok) begin
            rem_q   <= rem_nx;
            buf_q   <= buf_q + WSTEP;
            state_q <= (rem_nx == '0) ? S_WB_STAT : S_RX_IN;
          end
          S_WB_STAT: if (acc_ok) state_q <= S_WB_CTRL;
          S_WB_CTRL: if (acc_ok) begin
            bd_done_o  <= ctrl_q[C_BDIRQ];
            pkt_done_o <= ctrl_q[C_PKTIRQ] && ctrl_q[C_LIFM];
            if (ctrl_q[C_EOL] || next_q == '0) begin
              state_q <= S_IDLE;
            end else begin
              bd_q    <= next_q;
              state_q <= S_RD_CTRL;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign pk_clear = (state_q == S_IDLE) || abort || (state_q == S_RX_WR && acc_ok);

  dbp_tx_unpack u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (abort || state_q == S_IDLE),
    .load_i  (state_q == S_TX_RD && acc_ok),
    .word_i  (mem_rdata_i),
    .cnt_i   (chunk),
    .ready_i (tx_ready_i),
    .valid_o (tx_valid_o),
    .data_o  (tx_data_o),
    .busy_o  (tx_busy)
  );

  dbp_rx_pack u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (pk_clear),
    .en_i     (state_q == S_RX_IN),
    .target_i (chunk),
    .valid_i  (rx_valid_i),
    .data_i   (rx_data_i),
    .ready_o  (rx_ready_o),
    .full_o   (rx_full),
    .word_o   (pk_word)
  );

  p_req_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && dma_en_i) |=> (mem_req_o && $stable(mem_addr_o)));
  p_cmd_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i && dma_en_i) |=> (cmd_valid_o && $stable(cmd_len_o)));
  p_evt_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!bd_done_o && !pkt_done_o));
  p_len_max_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_len_o <= LEN_LIM));
  p_err_halt_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !mem_req_o);
  p_abort_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i |=> (!mem_req_o && !cmd_valid_o));
endmodule

// File: tb/sim_dbp_walker.sv
`timescale 1ns/1ps
module sim_dbp_walker;
  localparam int AW = 32;
  localparam logic [31:0] OWN = 32'h8000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic dma_en = 1'b0, poll_en = 1'b0, start = 1'b0;
  logic [AW-1:0] base = '0;
  logic mem_req, mem_we, mem_ack, mem_err;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic cmd_valid, cmd_ready, cmd_rx, cmd_lsb, cmd_rel;
  logic [8:0] cmd_len;
  logic [1:0] cmd_lanes, cmd_dev;
  logic tx_valid, tx_ready, rx_valid, rx_ready;
  logic [7:0] tx_data, rx_data;
  logic bd_done, pkt_done, err;

  dbp_walker u0 (
    .clk_i(clk), .rst_ni(rst_n), .dma_en_i(dma_en), .poll_en_i(poll_en),
    .start_i(start), .base_addr_i(base),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .mem_err_i(mem_err),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_len_o(cmd_len),
    .cmd_rx_o(cmd_rx), .cmd_lanes_o(cmd_lanes), .cmd_lsb_o(cmd_lsb),
    .cmd_dev_o(cmd_dev), .cmd_cs_rel_o(cmd_rel),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_data_i(rx_data),
    .bd_done_o(bd_done), .pkt_done_o(pkt_done), .err_o(err)
  );

  // memory model; the bench writes through the host port
  logic [31:0] mem [0:255];
  logic h_we = 1'b0;
  logic [7:0] h_idx = '0;
  logic [31:0] h_wd = '0;
  logic [AW-1:0] fault_addr = '1;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
      mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
    end else begin
      if (h_we) mem[h_idx] <= h_wd;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        mem_err <= (mem_addr == fault_addr);
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[9:2]];
      end else begin
        mem_ack <= 1'b0; mem_err <= 1'b0;
      end
    end
  end

  // shifter model
  logic [7:0] cyc = '0;
  logic tx_gate = 1'b1;
  always @(posedge clk) cyc <= cyc + 8'd1;
  assign cmd_ready = (cyc[2:0] != 3'd0);
  assign tx_ready  = tx_gate && (cyc[1:0] != 2'd3);
  logic [7:0] rx_bytes [0:15];
  int rx_cnt = 0, rx_idx = 0;
  logic rx_rst = 1'b0;
  assign rx_valid = (rx_idx < rx_cnt);
  assign rx_data  = rx_bytes[rx_idx[3:0]];
  always @(posedge clk) begin
    if (rx_rst) rx_idx <= 0;
    else if (rx_valid && rx_ready) rx_idx <= rx_idx + 1;
  end

  int n_chk = 0, n_err = 0;
  int cmd_seen = 0, bd_cnt = 0, pkt_cnt = 0, err_cnt = 0;
  logic [15:0] exp_cmd [$];
  logic [7:0]  exp_tx [$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mkcmd(int len, bit rx, int lanes, bit lsb, int dev, bit rel);
    return {len[8:0], rx, lanes[1:0], lsb, dev[1:0], rel};
  endfunction

  // monitor: pop expected items as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid && cmd_ready) begin
        cmd_seen++;
        if (exp_cmd.size() == 0) check("R2 unexpected command", 32'(cmd_len), 32'hFFFF_FFFF);
        else check("R2 command fields",
                   32'({cmd_len, cmd_rx, cmd_lanes, cmd_lsb, cmd_dev, cmd_rel}),
                   32'(exp_cmd.pop_front()));
      end
      if (tx_valid && tx_ready) begin
        if (exp_tx.size() == 0) check("R3 unexpected tx byte", 32'(tx_data), 32'hFFFF_FFFF);
        else check("R3 tx byte", 32'(tx_data), 32'(exp_tx.pop_front()));
      end
      if (bd_done)  bd_cnt++;
      if (pkt_done) pkt_cnt++;
      if (err)      err_cnt++;
    end
  end

  task automatic poke(int idx, logic [31:0] v);
    @(negedge clk); h_we = 1'b1; h_idx = idx[7:0]; h_wd = v;
    @(negedge clk); h_we = 1'b0;
  endtask

  task automatic put_desc(int addr, logic [31:0] c, logic [31:0] b, logic [31:0] n);
    poke(addr/4, c); poke(addr/4 + 1, 32'h0); poke(addr/4 + 2, b); poke(addr/4 + 3, n);
  endtask

  task automatic go(int addr);
    bd_cnt = 0; pkt_cnt = 0; err_cnt = 0;
    base = AW'(addr);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 12) begin
      @(negedge clk);
      if (mem_req || cmd_valid || tx_valid) q = 0; else q++;
    end
  endtask

  task automatic queues_empty(string tag);
    check({tag, " commands left"}, 32'(exp_cmd.size()), 0);
    check({tag, " tx bytes left"}, 32'(exp_tx.size()), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R12 idle outputs)
    check("R12 reset mem_req", 32'(mem_req), 0);
    check("R12 reset cmd_valid", 32'(cmd_valid), 0);
    check("R12 reset tx_valid", 32'(tx_valid), 0);
    check("R6 reset events", 32'({bd_done, pkt_done, err}), 0);
    dma_en = 1'b1;

    // chain: R1 R2 R3 R5 R6 R7 R8
    put_desc(32'h40, 32'h9081_0006, 32'h100, 32'h60);
    put_desc(32'h60, 32'hC24F_0003, 32'h140, 32'h80);
    put_desc(32'h80, 32'h8001_0001, 32'h140, 32'h0);
    poke(32'h40, 32'h4433_2211); poke(32'h41, 32'h8877_6655); poke(32'h50, 32'hCCBB_AA99);
    exp_cmd.push_back(mkcmd(6, 0, 2, 0, 1, 0));
    exp_cmd.push_back(mkcmd(3, 0, 1, 1, 0, 1));
    foreach (exp_tx[i]) ;
    exp_tx.push_back(8'h11); exp_tx.push_back(8'h22); exp_tx.push_back(8'h33);
    exp_tx.push_back(8'h44); exp_tx.push_back(8'h55); exp_tx.push_back(8'h66);
    exp_tx.push_back(8'h99); exp_tx.push_back(8'hAA); exp_tx.push_back(8'hBB);
    go(32'h40); wait_quiet();
    queues_empty("R3 chain");
    check("R5 ctrl0 ownership released", mem[16], 32'h1081_0006);
    check("R5 status0", mem[17], 32'h8000_0006);
    check("R5 status1", mem[25], 32'h8000_0003);
    check("R8 end-of-list stops walk", mem[32], 32'h8001_0001);
    check("R6 bd_done count", 32'(bd_cnt), 2);
    check("R7 pkt_done count", 32'(pkt_cnt), 1);

    // receive, stop on null link: R4 R7 R8
    poke(32'h60, 32'hFFFF_FFFF); poke(32'h61, 32'hFFFF_FFFF);
    for (int i = 0; i < 5; i++) rx_bytes[i] = 8'(i + 1);
    @(negedge clk); rx_rst = 1'b1; @(negedge clk); rx_rst = 1'b0; rx_cnt = 5;
    put_desc(32'hA0, 32'h8016_0005, 32'h180, 32'h0);
    exp_cmd.push_back(mkcmd(5, 1, 0, 0, 0, 0));
    go(32'hA0); wait_quiet();
    queues_empty("R4 rx");
    check("R4 rx word0", mem[96], 32'h0403_0201);
    check("R4 rx partial word1", mem[97], 32'h0000_0005);
    check("R7 rx pkt_done", 32'(pkt_cnt), 1);
    check("R6 rx no bd_done", 32'(bd_cnt), 0);
    check("R5 rx status", mem[41], 32'h8000_0005);
    rx_cnt = 0;

    // zero length: R13
    put_desc(32'hC0, 32'h8009_0000, 32'h1C0, 32'hE0);
    exp_cmd.push_back(mkcmd(0, 0, 0, 0, 0, 0));
    go(32'hC0); wait_quiet();
    queues_empty("R13 zero length");
    check("R13 zero status", mem[49], 32'h8000_0000);
    check("R13 zero bd_done", 32'(bd_cnt), 1);

    // unowned without poll: R9
    put_desc(32'hE0, 32'h0009_0002, 32'h1C0, 32'h0);
    poke(32'h70, 32'h0000_BEEF);
    c0 = cmd_seen;
    go(32'hE0); wait_quiet();
    check("R9 unowned error", 32'(err_cnt), 1);
    check("R9 unowned no command", 32'(cmd_seen), 32'(c0));
    check("R9 unowned ctrl untouched", mem[56], 32'h0009_0002);

    // unowned with poll: R9
    poll_en = 1'b1;
    exp_cmd.push_back(mkcmd(2, 0, 0, 0, 0, 0));
    exp_tx.push_back(8'hEF); exp_tx.push_back(8'hBE);
    go(32'hE0);
    repeat (40) @(negedge clk);
    check("R9 poll waits without command", 32'(cmd_seen), 32'(c0));
    check("R9 poll no error", 32'(err_cnt), 0);
    poke(56, 32'h8009_0002);
    wait_quiet();
    queues_empty("R9 poll");
    check("R9 poll completes", 32'(bd_cnt), 1);
    check("R5 poll ctrl write-back", mem[56], 32'h0009_0002);
    poll_en = 1'b0;

    // oversize length: R10
    put_desc(32'h200, 32'h8000_012C, 32'h300, 32'h0);
    c0 = cmd_seen;
    go(32'h200); wait_quiet();
    check("R10 oversize error", 32'(err_cnt), 1);
    check("R10 oversize no command", 32'(cmd_seen), 32'(c0));

    // faulted buffer read: R11
    put_desc(32'h210, 32'h8001_0008, 32'h300, 32'h0);
    fault_addr = 32'h300;
    exp_cmd.push_back(mkcmd(8, 0, 0, 0, 0, 0));
    go(32'h210); wait_quiet();
    fault_addr = '1;
    queues_empty("R11 fault");
    check("R11 fault error", 32'(err_cnt), 1);
    check("R11 fault no bd_done", 32'(bd_cnt), 0);
    check("R11 fault no status write", mem[133], 32'h0);

    // abort mid payload: R12
    put_desc(32'h220, 32'h8001_00C8, 32'h340, 32'h0);
    tx_gate = 1'b0;
    exp_cmd.push_back(mkcmd(200, 0, 0, 0, 0, 0));
    c0 = cmd_seen;
    go(32'h220);
    while (cmd_seen == c0) @(negedge clk);
    repeat (6) @(negedge clk);
    dma_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 abort mem_req low", 32'(mem_req), 0);
    check("R12 abort tx_valid low", 32'(tx_valid), 0);
    check("R12 abort cmd_valid low", 32'(cmd_valid), 0);
    repeat (10) @(negedge clk);
    check("R12 abort no status write", mem[137], 32'h0);
    check("R12 abort no events", 32'(bd_cnt + err_cnt), 0);
    queues_empty("R12 abort");
    tx_gate = 1'b1;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule